// File: doc/BRIEF.md
# Complex Baseband FM Discriminator

This block turns a constant-envelope FM signal into its message once the signal has been moved to complex baseband and lowpass filtered. Every accepted in-phase/quadrature sample pair is combined with the pair accepted before it. The block forms the cross product of the current sample with the backward first difference of each component. The result follows the derivative of the phasor angle, so its amplitude tracks the instantaneous frequency deviation. A sinusoidal message therefore comes back out as a sinusoid.

The envelope of an FM signal is constant, so the block never divides by the squared magnitude. The gain depends on the square of the signal amplitude. The output is kept at full precision. A parameter can apply an arithmetic right shift to trade low-order bits for a narrower port. The pipeline has two register stages: the first stores the sample and its differences, the second performs the multiply-subtract.

Top module: `fm_slope_demod`

## Requirements
- R1: For accepted samples n-1 and n, the output equals I[n]*(Q[n]-Q[n-1]) - Q[n]*(I[n]-I[n-1]), computed exactly as a two's complement value of 2*IN_W+2 bits and shifted arithmetically right by SHIFT. SHIFT is 0 by default, which makes out_z 26 bits wide for 12-bit inputs. The result is not normalized by the magnitude.
- R2: The stored previous sample changes only in a cycle where in_vld is high. The value on in_i/in_q in idle cycles has no effect on later results, however many idle cycles fall between two samples.
- R3: A repeated constant input (a non-rotating phasor) gives an output of exactly zero for every sample after the first.
- R4: A phasor that advances by a fixed angle each sample gives a positive output, and the same phasor turning the other way gives the negated value. A 90-degree step of amplitude A gives +A*A for counter-clockwise rotation and -A*A for clockwise rotation.
- R5: out_vld is high in cycle k+2 exactly when in_vld was high in cycle k. There is one result per accepted sample, and consecutive samples can arrive on back-to-back cycles.
- R6: out_z holds its last value in every cycle where out_vld is low.
- R7: An active-low reset clears the stored previous sample and the outputs to zero. As a result, the first output after reset is I*Q - Q*I = 0.
- R8: Full-scale inputs (-2^(IN_W-1) and 2^(IN_W-1)-1 on either component) never overflow the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | IN_W | In-phase sample, signed |
| in_q | input | IN_W | Quadrature sample, signed |
| out_vld | output | 1 | Output sample strobe |
| out_z | output | 2*IN_W+2-SHIFT | Discriminator output, signed |

## Verification
The hardest case to reach from the ports is a stored sample that is wrongly overwritten during an idle cycle. That fault is invisible unless the idle-cycle data differs from the last accepted sample and a further sample follows. The stimulus therefore drives random junk on in_i/in_q whenever in_vld is low and inserts gaps of varying length between samples. Rotating phasors are built from sine and cosine in both directions, and full-scale corner sequences cover the growth in word width. A reset in the middle of a run confirms that the next output starts again from zero.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

    // Default sample width of the discriminator inputs.
    localparam int unsigned FMD_DEF_IN_W = 12;

    // Exact width of I*dQ - Q*dI for w-bit samples and (w+1)-bit differences.
    function automatic int unsigned fmd_full_w(input int unsigned w);
        return 2 * w + 2;
    endfunction

endpackage

// File: rtl/fmd_diff_stage.sv
module fmd_diff_stage #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_i,
    input  logic [W-1:0] in_q,
    output logic         vld_o,
    output logic [W-1:0] samp_i,
    output logic [W-1:0] samp_q,
    output logic [W:0]   dlt_i,
    output logic [W:0]   dlt_q
);
    localparam int unsigned DW = W + 1;

    typedef struct packed {
        logic          vld;
        logic [W-1:0]  s_i;
        logic [W-1:0]  s_q;
        logic [DW-1:0] d_i;
        logic [DW-1:0] d_q;
    } dstg_t;

    dstg_t st_d, st_q;

    // The stored sample doubles as the history for the next difference.
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.s_i = in_i;
            st_d.s_q = in_q;
            st_d.d_i = $signed({in_i[W-1], in_i}) - $signed({st_q.s_i[W-1], st_q.s_i});
            st_d.d_q = $signed({in_q[W-1], in_q}) - $signed({st_q.s_q[W-1], st_q.s_q});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign samp_i = st_q.s_i;
    assign samp_q = st_q.s_q;
    assign dlt_i  = st_q.d_i;
    assign dlt_q  = st_q.d_q;

    // R2: history is frozen across idle cycles
    p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(st_q.s_i) && $stable(st_q.s_q)));

    // R2: an accepted sample is what is stored
    p_hist_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (st_q.s_i == $past(in_i) && st_q.s_q == $past(in_q)));

endmodule

// File: rtl/fmd_xprod_stage.sv
module fmd_xprod_stage #(
    parameter int unsigned W     = 12,
    parameter int unsigned SHIFT = 0,
    localparam int unsigned FW   = fmd_pkg::fmd_full_w(W),
    localparam int unsigned OW   = FW - SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [W-1:0]  s_i,
    input  logic [W-1:0]  s_q,
    input  logic [W:0]    d_i,
    input  logic [W:0]    d_q,
    output logic          vld_o,
    output logic [OW-1:0] z_o
);
    typedef struct packed {
        logic          vld;
        logic [OW-1:0] z;
    } xstg_t;

    xstg_t st_d, st_q;

    logic signed [FW-1:0] si_x, sq_x, di_x, dq_x, full_v, shr_v;

    always_comb begin
        si_x   = FW'($signed(s_i));
        sq_x   = FW'($signed(s_q));
        di_x   = FW'($signed(d_i));
        dq_x   = FW'($signed(d_q));
        full_v = si_x * dq_x - sq_x * di_x;
        shr_v  = full_v >>> SHIFT;
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) st_d.z = shr_v[OW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign z_o   = st_q.z;

    // R3: no change between samples means no output
    p_static_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && d_i == '0 && d_q == '0) |=> (z_o == '0));

    // R6: output data is held while no result is presented
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(z_o));

endmodule

// File: rtl/fm_slope_demod.sv
module fm_slope_demod #(
    parameter int unsigned IN_W   = fmd_pkg::FMD_DEF_IN_W,
    parameter int unsigned SHIFT  = 0,
    localparam int unsigned OUT_W = fmd_pkg::fmd_full_w(IN_W) - SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_i,
    input  logic [IN_W-1:0]  in_q,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_z
);
    logic            s1_vld;
    logic [IN_W-1:0] s1_i, s1_q;
    logic [IN_W:0]   s1_di, s1_dq;

    fmd_diff_stage #(.W(IN_W)) u_diff (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .in_i   (in_i),
        .in_q   (in_q),
        .vld_o  (s1_vld),
        .samp_i (s1_i),
        .samp_q (s1_q),
        .dlt_i  (s1_di),
        .dlt_q  (s1_dq)
    );

    fmd_xprod_stage #(.W(IN_W), .SHIFT(SHIFT)) u_xprod (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (s1_vld),
        .s_i   (s1_i),
        .s_q   (s1_q),
        .d_i   (s1_di),
        .d_q   (s1_dq),
        .vld_o (out_vld),
        .z_o   (out_z)
    );

    // R5: every accepted sample yields a result two cycles later
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##2 out_vld);

    // R5: no result without an accepted sample
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |-> ##2 !out_vld);

endmodule

// File: tb/test_fm_slope_demod.sv
module test_fm_slope_demod;
    localparam int IN_W  = 12;
    localparam int OUT_W = 2 * IN_W + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_vld = 1'b0;
    logic [IN_W-1:0]  in_i = '0;
    logic [IN_W-1:0]  in_q = '0;
    logic             out_vld;
    logic [OUT_W-1:0] out_z;

    fm_slope_demod #(.IN_W(IN_W)) i_fm_slope_demod (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
        .out_vld(out_vld), .out_z(out_z)
    );

    always #2.5 clk = ~clk;

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    longint mi = 0, mq = 0;
    logic [OUT_W-1:0] last_z = '0;

    longint exp_q[$];
    longint cyc_q[$];
    string  tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Monitor: compares results as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_vld) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R5 unexpected result: actual %0d expected none", $signed(out_z));
                end else begin
                    longint e, ec;
                    string  t;
                    e = exp_q.pop_front(); ec = cyc_q.pop_front(); t = tag_q.pop_front();
                    n_chk++;
                    if (longint'($signed(out_z)) != e) begin
                        n_bad++;
                        $display("FAIL %s value: actual %0d expected %0d", t, $signed(out_z), e);
                    end
                    n_chk++;
                    if (cyc != ec) begin
                        n_bad++;
                        $display("FAIL R5 latency: actual cycle %0d expected %0d", cyc, ec);
                    end
                end
                last_z = out_z;
            end else begin
                n_chk++;
                if (out_z !== last_z) begin
                    n_bad++;
                    $display("FAIL R6 hold: actual %0d expected %0d", $signed(out_z), $signed(last_z));
                end
            end
        end
    end

    // Driver: one sample, idle data is randomised (R2)
    task automatic send(input int i, input int q, input string tag);
        longint e;
        e = longint'(i) * (longint'(q) - mq) - longint'(q) * (longint'(i) - mi);
        mi = i; mq = q;
        exp_q.push_back(e); cyc_q.push_back(cyc + 2); tag_q.push_back(tag);
        in_i = IN_W'(i); in_q = IN_W'(q); in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        in_i = IN_W'($urandom); in_q = IN_W'($urandom);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_vld = 1'b0;
        idle(3);
        n_chk++;
        if (out_vld !== 1'b0 || out_z !== '0) begin
            n_bad++;
            $display("FAIL R7 reset outputs: actual vld=%0b z=%0d expected vld=0 z=0", out_vld, $signed(out_z));
        end
        mi = 0; mq = 0; last_z = '0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int rnd_s();
        return int'($urandom_range(4095)) - 2048;
    endfunction

    initial begin
        int a;
        real th;
        do_reset();

        // R7: first sample after reset gives zero
        send(1000, -700, "R7");
        idle(3);

        // R3: constant phasor
        for (int k = 0; k < 4; k++) send(-1200, 900, "R3");
        idle(3);

        // R4: 90-degree steps, counter-clockwise gives +A*A then clockwise -A*A
        a = 1500;
        send(a, 0, "R4");
        send(0, a, "R4 +");
        send(-a, 0, "R4 +");
        send(0, -a, "R4 +");
        send(-a, 0, "R4 -");
        send(0, a, "R4 -");
        idle(2);

        // R4: finer rotations both ways
        th = 3.14159265358979 / 7.0;
        for (int k = 0; k < 20; k++)
            send($rtoi($floor(1800.0 * $cos(k * th) + 0.5)), $rtoi($floor(1800.0 * $sin(k * th) + 0.5)), "R4 ccw");
        for (int k = 0; k < 20; k++)
            send($rtoi($floor(1800.0 * $cos(-k * th) + 0.5)), $rtoi($floor(1800.0 * $sin(-k * th) + 0.5)), "R4 cw");
        idle(3);

        // R2: gaps with junk on the data lines
        for (int k = 0; k < 30; k++) begin
            send(rnd_s(), rnd_s(), "R2");
            idle(1 + (k % 5));
        end

        // R8: full-scale corners
        send(-2048, -2048, "R8");
        send(2047, -2048, "R8");
        send(-2048, 2047, "R8");
        send(2047, 2047, "R8");
        send(-2048, 2047, "R8");
        send(2047, -2048, "R8");
        send(-2048, -2048, "R8");
        idle(3);

        // R1: back-to-back random samples
        for (int k = 0; k < 60; k++) send(rnd_s(), rnd_s(), "R1");
        idle(4);

        // R7: reset mid-run clears history
        send(700, 300, "R1");
        idle(4);
        do_reset();
        send(-1500, 1100, "R7");
        send(-1400, 1200, "R1");
        idle(5);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R5 missing results: actual %0d pending expected 0", exp_q.size());
        end
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R5 watchdog expired: actual running expected finished");
        summary();
        $finish;
    end

endmodule